// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. Its pipeline lets reads and writes follow each other on the data bus without idle cycles. Address and control are captured on a rising clock edge. The data beat for that request, whether read or write, happens two rising edges later. Because writes carry the same two-edge lag as reads, the bus never needs a turnaround gap when the direction changes.

An on-chip burst counter can step through four words from a single loaded address, in either linear or interleaved order. Each 36-bit word is split into four 9-bit lanes, and each lane has its own active-low write enable.

A clock-enable input and a sleep input each freeze the whole block as if the clock edge had not occurred. Three chip enables qualify each load. An asynchronous output enable can take the bus off at any moment. The tristate bus is split into a write-data input, a read-data output and a drive-enable output.

Top module: `zbt_sram`

## Requirements
- R1: A read loaded at rising edge k makes `rdata_oe` high, with `rdata` equal to the stored word, during the cycle that follows edge k+2.
- R2: A write loaded at edge k stores `wdata` as sampled at edge k+2. A read of that address loaded afterwards returns the new word.
- R3: Loads may alternate between read and write on consecutive edges with no idle cycle. A write at edge k followed by a read of the same address at edge k+1 returns the written data.
- R4: When `clk_en_n` is high at an edge, all inputs are ignored, no register or array word changes, and both outputs keep their values.
- R5: A load (`advance`=0) in which any chip enable is inactive (`ce_a_n`=1, `ce_b`=0 or `ce_c_n`=1) starts no access and ends any burst. Operations already in the pipeline still complete, and `rdata_oe` is low after edge k+2 of such a deselect.
- R6: After edge k+2 of a write loaded at edge k, `rdata_oe` is low in the following cycle.
- R7: Byte lane i is `wdata`/`rdata` bits [9i+8:9i] and is written only when `byte_wr_n[i]` is 0. `byte_wr_n` is sampled with each load and with each burst beat. Lanes that are not enabled keep their old contents, and `byte_wr_n` has no effect on reads.
- R8: `oe_n` high forces `rdata_oe` low at once, without waiting for a clock. With `oe_n` low, `rdata_oe` follows the pipeline.
- R9: When `sleep` is high at an edge, the block behaves as in R4, and the array keeps its contents.
- R10: With a burst in progress, `advance`=1 repeats the burst's read or write at the next address, and `addr` and `rd_wr` are ignored. With `burst_interleave`=0, the low two address bits of beat n are (start + n) mod 4, and the upper bits stay fixed.
- R11: With `burst_interleave`=1, the low two address bits of beat n are start XOR n.
- R12: `advance`=1 when no burst is in progress (after reset or after a deselect) starts no access.
- R13: A synchronous high `rst` clears both pipeline stages to idle and drives `rdata_oe` low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the block |
| sleep | input | 1 | High gates the internal clock; contents kept |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| advance | input | 1 | 1 = step the burst, 0 = load a new request |
| rd_wr | input | 1 | On a load: 1 = read, 0 = write |
| byte_wr_n | input | 4 | Active-low write enable per 9-bit lane |
| burst_interleave | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| addr | input | 8 | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | 36 | Write data, sampled two edges after its load |
| rdata | output | 36 | Read data from the output register |
| rdata_oe | output | 1 | High when the block drives `rdata` onto the bus |

## Verification
The bench first fills the array with full-word writes and then reads it back in single-address runs, which separates a correct two-edge lag from a lag of one or three edges. Dense alternation of writes and reads to the same address shows whether a write lands before a read loaded one edge later. Partial lane masks on writes, and deliberately random masks on reads, show which lanes are touched and confirm that reads ignore the mask. Linear and interleaved bursts from every start offset, deselects and stray advances, and stalls from both the clock enable and the sleep input in the middle of traffic, check the burst counter and the pipeline freeze.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_burst_gen.sv
// First pipeline stage: captures loads and steps the burst counter.
module zbt_burst_gen
  import zbt_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LANES      = 4,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              advance,
  input  logic              selected,
  input  logic              rd_req,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LANES-1:0]  ben_n_in,
  output op_e               cur_op,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LANES-1:0]  cur_ben_n
);
  localparam int HI_W = ADDR_W - BURST_BITS;

  op_e                   op_q;
  logic [ADDR_W-1:0]     base_q;
  logic [BURST_BITS-1:0] cnt_q;
  logic [LANES-1:0]      ben_q;
  logic [BURST_BITS-1:0] low_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      cnt_q  <= '0;
      base_q <= '0;
      ben_q  <= '1;
    end else if (en) begin
      ben_q <= ben_n_in;
      if (!advance) begin
        if (selected) begin
          op_q   <= rd_req ? OP_READ : OP_WRITE;
          base_q <= addr_in;
          cnt_q  <= '0;
        end else begin
          op_q <= OP_IDLE;
        end
      end else if (op_q != OP_IDLE) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (interleave) low_bits = base_q[BURST_BITS-1:0] ^ cnt_q;
    else            low_bits = base_q[BURST_BITS-1:0] + cnt_q;
  end

  assign cur_op    = op_q;
  assign cur_addr  = {base_q[ADDR_W-1 -: HI_W], low_bits};
  assign cur_ben_n = ben_q;

  assert_idle_stays_R12: assert property (@(posedge clk) disable iff (rst)
    (en && advance && op_q == OP_IDLE) |=> op_q == OP_IDLE);

  assert_burst_step_R10: assert property (@(posedge clk) disable iff (rst)
    (en && advance && op_q != OP_IDLE) |=>
      (op_q == $past(op_q)) && (base_q == $past(base_q)) && (cnt_q == $past(cnt_q) + 1'b1));

  assert_deselect_R5: assert property (@(posedge clk) disable iff (rst)
    (en && !advance && !selected) |=> op_q == OP_IDLE);
endmodule

// File: rtl/zbt_pipe_stage.sv
// Second pipeline stage: delays the request by one more enabled edge.
module zbt_pipe_stage
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  op_e               op_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LANES-1:0]  ben_n_in,
  output op_e               op_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic [LANES-1:0]  ben_n_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      op_out    <= OP_IDLE;
      addr_out  <= '0;
      ben_n_out <= '1;
    end else if (en) begin
      op_out    <= op_in;
      addr_out  <= addr_in;
      ben_n_out <= ben_n_in;
    end
  end

  assert_stage_follow_R1: assert property (@(posedge clk) disable iff (rst)
    en |=> (op_out == $past(op_in)) && (addr_out == $past(addr_in)));

  assert_reset_idle_R13: assert property (@(posedge clk)
    rst |=> op_out == OP_IDLE);
endmodule

// File: rtl/zbt_lane_ram.sv
// One byte lane of the array: single port, registered read.
module zbt_lane_ram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rd <= mem[addr];
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LANES      = 4,
  parameter int LANE_W     = 9,
  parameter int BURST_BITS = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clk_en_n,
  input  logic                      sleep,
  input  logic                      ce_a_n,
  input  logic                      ce_b,
  input  logic                      ce_c_n,
  input  logic                      advance,
  input  logic                      rd_wr,
  input  logic [LANES-1:0]          byte_wr_n,
  input  logic                      burst_interleave,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      oe_n,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rdata_oe
);
  localparam int DATA_W = LANES * LANE_W;

  logic              en;
  logic              selected;
  op_e               a_op, b_op;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [LANES-1:0]  a_ben_n, b_ben_n;
  logic              drive_q;
  logic              do_read;
  logic [DATA_W-1:0] rd_word;

  assign en       = !clk_en_n && !sleep;
  assign selected = !ce_a_n && ce_b && !ce_c_n;

  zbt_burst_gen #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_BITS(BURST_BITS)) u_burst (
    .clk(clk), .rst(rst), .en(en), .advance(advance), .selected(selected),
    .rd_req(rd_wr), .interleave(burst_interleave), .addr_in(addr),
    .ben_n_in(byte_wr_n), .cur_op(a_op), .cur_addr(a_addr), .cur_ben_n(a_ben_n)
  );

  zbt_pipe_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_stage (
    .clk(clk), .rst(rst), .en(en), .op_in(a_op), .addr_in(a_addr),
    .ben_n_in(a_ben_n), .op_out(b_op), .addr_out(b_addr), .ben_n_out(b_ben_n)
  );

  assign do_read = en && !rst && (b_op == OP_READ);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_we;
    assign lane_we = en && !rst && (b_op == OP_WRITE) && !b_ben_n[g];
    zbt_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
      .clk(clk), .we(lane_we), .re(do_read), .addr(b_addr),
      .wd(wdata[g*LANE_W +: LANE_W]), .rd(rd_word[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)     drive_q <= 1'b0;
    else if (en) drive_q <= (b_op == OP_READ);
  end

  assign rdata    = rd_word;
  assign rdata_oe = drive_q && !oe_n;

  assert_read_drives_R1: assert property (@(posedge clk) disable iff (rst)
    (en && b_op == OP_READ) |=> drive_q);

  assert_write_releases_R6: assert property (@(posedge clk) disable iff (rst)
    (en && b_op == OP_WRITE) |=> !drive_q);

  assert_idle_releases_R5: assert property (@(posedge clk) disable iff (rst)
    (en && b_op == OP_IDLE) |=> !drive_q);

  assert_stall_holds_R4: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> $stable(drive_q) && $stable(b_op) && $stable(a_op));

  assert_sleep_holds_R9: assert property (@(posedge clk) disable iff (rst)
    sleep |=> $stable(drive_q) && $stable(b_op) && $stable(b_addr));
endmodule

// File: tb/test_zbt_sram.sv
module test_zbt_sram;
  localparam int AW = 8;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1, clk_en_n = 1'b0, sleep = 1'b0;
  logic          ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
  logic          advance = 1'b0, rd_wr = 1'b1, burst_interleave = 1'b0, oe_n = 1'b0;
  logic [LN-1:0] byte_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  zbt_sram i_zbt_sram (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sleep(sleep),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .advance(advance),
    .rd_wr(rd_wr), .byte_wr_n(byte_wr_n), .burst_interleave(burst_interleave),
    .addr(addr), .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int    n_chk = 0, n_bad = 0;
  string tag = "R13";
  logic  armed = 1'b0;

  // shadow controls applied at the next negedge
  logic b_rst = 1'b1, b_cen = 1'b0, b_sleep = 1'b0, b_oe = 1'b0, b_il = 1'b0;

  // reference model
  logic [DW-1:0] ref_mem [0:255];
  int            m_op = 0, m_cnt = 0, s_op = 0;
  logic [AW-1:0] m_base = '0, s_addr = '0;
  logic [LN-1:0] m_ben = '1, s_ben = '1;
  logic          exp_drv = 1'b0;
  logic [DW-1:0] exp_q = '0;

  function automatic logic [AW-1:0] beat_addr();
    logic [1:0] lo;
    lo = burst_interleave ? (m_base[1:0] ^ 2'(m_cnt)) : (m_base[1:0] + 2'(m_cnt));
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check_outputs();
    logic eo;
    eo = exp_drv && !oe_n;
    n_chk++;
    if (rdata_oe !== eo) begin
      n_bad++;
      $display("FAIL %s rdata_oe actual=%0b expected=%0b t=%0t", tag, rdata_oe, eo, $time);
    end
    if (eo) begin
      n_chk++;
      if (rdata !== exp_q) begin
        n_bad++;
        $display("FAIL %s rdata actual=%h expected=%h t=%0t", tag, rdata, exp_q, $time);
      end
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      m_op = 0; s_op = 0; exp_drv = 1'b0;
    end else if (!clk_en_n && !sleep) begin
      if (s_op == 2)
        for (int i = 0; i < LN; i++)
          if (!s_ben[i]) ref_mem[s_addr][i*LW +: LW] = wdata[i*LW +: LW];
      if (s_op == 1) exp_q = ref_mem[s_addr];
      exp_drv = (s_op == 1);
      s_op   = m_op;
      s_addr = beat_addr();
      s_ben  = m_ben;
      if (!advance) begin
        if (!ce_a_n && ce_b && !ce_c_n) begin
          m_op = rd_wr ? 1 : 2; m_base = addr; m_cnt = 0;
        end else m_op = 0;
      end else if (m_op != 0) m_cnt = (m_cnt + 1) % 4;
      m_ben = byte_wr_n;
    end
  endtask

  // ces = {ce_a_n, ce_b, ce_c_n}; 3'b010 selects
  task automatic cyc(input logic adv, input logic rd, input logic [AW-1:0] a,
                     input logic [LN-1:0] ben, input logic [2:0] ces);
    @(negedge clk);
    rst = b_rst; clk_en_n = b_cen; sleep = b_sleep; oe_n = b_oe; burst_interleave = b_il;
    advance = adv; rd_wr = rd; addr = a; byte_wr_n = ben;
    {ce_a_n, ce_b, ce_c_n} = ces;
    wdata = {4'($urandom), 32'($urandom)};
    #1;
    if (armed) check_outputs();
    model_edge();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [LN-1:0] ben);
    cyc(1'b0, 1'b0, a, ben, 3'b010);
  endtask
  task automatic rd(input logic [AW-1:0] a);
    cyc(1'b0, 1'b1, a, 4'($urandom), 3'b010);
  endtask
  task automatic nop();
    cyc(1'b0, 1'b1, '0, '1, 3'b000);
  endtask
  task automatic adv_beat(input logic [LN-1:0] ben);
    cyc(1'b1, 1'b0, 8'($urandom), ben, 3'($urandom));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R13: reset state
    b_rst = 1'b1;
    repeat (3) nop();
    armed = 1'b1;
    tag = "R13";
    check_outputs();
    b_rst = 1'b0;

    // R2: fill the array with full-word writes
    tag = "R2";
    for (int a = 0; a < 256; a++) wr(8'(a), 4'b0000);
    nop(); nop();

    // R1: single reads, spaced and back to back
    tag = "R1";
    for (int a = 0; a < 40; a++) begin
      rd(8'(a * 7));
      if (a % 3 == 0) nop();
    end
    nop(); nop();

    // R3: alternating write and read, same and different addresses
    tag = "R3";
    for (int a = 0; a < 30; a++) begin
      wr(8'(a + 100), 4'b0000);
      rd(8'(a + 100));
      rd(8'(a + 50));
      wr(8'(a + 50), 4'b0000);
    end
    nop(); nop();

    // R7: partial lane masks, then reads with random masks
    tag = "R7";
    for (int a = 0; a < 16; a++) wr(8'(a + 10), 4'(a));
    for (int a = 0; a < 16; a++) rd(8'(a + 10));
    nop(); nop();

    // R5: deselects mixed into traffic, each chip-enable pattern
    tag = "R5";
    for (int a = 0; a < 8; a++) begin
      rd(8'(a));
      cyc(1'b0, 1'b1, 8'(a), '1, 3'(a == 2 ? 3'b010 ^ 3'b001 : 3'(a) ^ 3'b010 | 3'b001));
      wr(8'(a + 1), 4'b0000);
      cyc(1'b0, 1'b0, 8'(a), 4'b0000, 3'b110);
      cyc(1'b0, 1'b0, 8'(a), 4'b0000, 3'b000);
      rd(8'(a + 1));
    end
    nop(); nop();

    // R6: write followed by idle bus
    tag = "R6";
    wr(8'd200, 4'b0000); nop(); nop(); nop();
    rd(8'd200); wr(8'd201, 4'b1010); nop(); nop(); nop();

    // R4: clock-enable stall in mid-pipeline
    tag = "R4";
    for (int a = 0; a < 10; a++) begin
      wr(8'(a + 30), 4'b0000);
      rd(8'(a + 30));
      b_cen = 1'b1;
      wr(8'(a + 31), 4'b0000);
      rd(8'(a + 90));
      b_cen = 1'b0;
      rd(8'(a + 31));
    end
    nop(); nop();

    // R9: sleep behaves like a gated clock, contents kept
    tag = "R9";
    for (int a = 0; a < 6; a++) begin
      rd(8'(a + 30));
      b_sleep = 1'b1;
      wr(8'(a + 30), 4'b0000);
      nop(); nop();
      b_sleep = 1'b0;
      rd(8'(a + 31));
    end
    nop(); nop();

    // R8: output enable removes drive at once
    tag = "R8";
    for (int a = 0; a < 12; a++) begin
      b_oe = (a % 3 == 1);
      rd(8'(a));
    end
    b_oe = 1'b0;
    nop(); nop();

    // R10: linear bursts from each start offset, write then read back
    tag = "R10";
    b_il = 1'b0;
    for (int s = 0; s < 4; s++) begin
      wr(8'(8'd64 + 8'(s)), 4'b0000);
      adv_beat(4'b0000); adv_beat(4'b0110); adv_beat(4'b0000);
      nop(); nop();
      rd(8'(8'd64 + 8'(s)));
      adv_beat(4'b1111); adv_beat(4'b0000); adv_beat(4'b1111); adv_beat(4'b0000);
      nop(); nop();
    end

    // R11: interleaved bursts from each start offset
    tag = "R11";
    b_il = 1'b1;
    nop();
    for (int s = 0; s < 4; s++) begin
      wr(8'(8'd128 + 8'(s)), 4'b0000);
      adv_beat(4'b0000); adv_beat(4'b0000); adv_beat(4'b1001);
      nop(); nop();
      rd(8'(8'd128 + 8'(s)));
      adv_beat(4'b0000); adv_beat(4'b0000); adv_beat(4'b0000);
      nop(); nop();
    end
    b_il = 1'b0;
    nop();

    // R12: advance with no burst in progress does nothing
    tag = "R12";
    nop();
    adv_beat(4'b0000); adv_beat(4'b0000); adv_beat(4'b0000);
    nop(); nop();
    rd(8'd129); rd(8'd130);
    nop(); nop();

    // R13: reset in the middle of reads and writes
    tag = "R13";
    rd(8'd5); wr(8'd6, 4'b0000);
    b_rst = 1'b1; nop();
    b_rst = 1'b0;
    nop(); nop(); nop();
    rd(8'd6); nop(); nop(); nop();

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule